// File: doc/BRIEF.md
# USB Device OUT Endpoint Controller

This block holds the control and status state of one device-side receive endpoint. A protocol engine reports the end of each OUT data packet together with its data PID, an incomplete marker and a PID-error marker. One cycle later the block answers with the handshake the engine must send: ACK, NYET, NAK, STALL, or none for isochronous traffic. It also tracks which receive buffers hold a packet ready for the CPU and keeps the expected data toggle.

The CPU sees one control/status word and one maximum-packet-size word. Several bits of the control/status word are actions. Writing 1 to them releases the oldest ready packet, clears the sticky stall-sent flag or zeroes the toggle. The unload side of the FIFO pulses a byte strobe. The block counts those bytes and can release a packet by itself when exactly the programmed maximum size has been read. A DMA request and a one-cycle interrupt pulse tell the rest of the system that packets are ready.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After synchronous reset the control/status word reads 0, the size word reads MAXP_RST (64), and `hs_valid`, `dma_req`, `irq` and `unload_cnt` are 0.
- R2: Each `pkt_done` pulse gives exactly one `hs_valid` pulse on the next cycle. `hs_code` encodes 0 none, 1 ACK, 2 NAK, 3 NYET, 4 STALL. When stall enable (bit 2) is set and isochronous mode (bit 6) is clear, the answer is STALL and no other state changes.
- R3: A non-isochronous packet whose PID matches the toggle (read at bit 10), arriving while a buffer is free, is stored. It sets packet-ready (bit 0) and flips the toggle, and `irq` pulses for one cycle if interrupt enable (bit 9) is set.
- R4: A non-isochronous packet whose PID does not match the toggle is answered ACK. It is discarded, and neither packet-ready nor the toggle changes.
- R5: A non-isochronous, non-stalled packet that arrives while all NUM_BUF buffers hold packets is answered NAK and changes no state.
- R6: In high-speed mode (`hs_mode`=1) with NYET suppression (bit 7) clear, a stored packet that occupies the last free buffer is answered NYET. With suppression set, it is answered ACK.
- R7: `unload_cnt` counts byte strobes while a packet is ready. With auto-release (bit 5) set, the strobe that brings the count to the value in the size word releases the packet and zeroes the count. Shorter reads leave packet-ready set.
- R8: Writing 1 to bit 0 while a packet is ready releases the oldest packet and zeroes `unload_cnt`. Packet-ready stays 1 while another packet remains.
- R9: Bit 4 shows the incomplete marker of the oldest ready packet only while high-bandwidth mode (bit 11) is set, and it reads 0 once that packet is released.
- R10: In isochronous mode there is no handshake (code 0), the stall enable and the toggle are ignored, a packet is stored if a buffer is free, and bit 7 reads the PID-error marker of the oldest ready packet.
- R11: Writing 1 to bit 3 sets the toggle to 0. Bit 3 reads 0.
- R12: A `stall_sent` pulse sets the sticky flag at bit 1, which stays set until the CPU writes 1 to bit 1.
- R13: `dma_req` is high exactly while DMA enable (bit 8) is set and a packet is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 1 | 0 = control/status word, 1 = max packet size word |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Read data of the addressed word |
| fifo_rd | input | 1 | One byte unloaded from the receive FIFO |
| unload_cnt | output | MAXP_W | Bytes unloaded from the oldest ready packet |
| hs_mode | input | 1 | Link runs at high speed |
| pkt_done | input | 1 | End of an OUT data packet |
| pkt_data1 | input | 1 | Packet carried the DATA1 PID |
| pkt_incomp | input | 1 | Parts of a high-bandwidth packet were missing |
| pkt_pid_err | input | 1 | PID error seen in the packet |
| stall_sent | input | 1 | Engine transmitted a STALL |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 3 | Handshake to send |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | One-cycle packet-received interrupt |

## Verification
The handshake decision is driven with matching and mismatched PIDs at zero, one and two occupied buffers. This separates ACK-and-store, ACK-and-drop, NYET and NAK, and each case is tried with high speed on and off and with NYET suppression set and clear. Stall and isochronous settings are crossed with these, which shows that stall overrides everything except isochronous mode. Unload strobes are sent in bursts shorter than, equal to and beyond the programmed size, with auto-release on and off. A fixed-seed random mix interleaves all of these against a reference model and also covers the per-packet incomplete and PID-error markers across releases.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;

    typedef enum logic [2:0] {
        HS_NONE  = 3'd0,
        HS_ACK   = 3'd1,
        HS_NAK   = 3'd2,
        HS_NYET  = 3'd3,
        HS_STALL = 3'd4
    } hs_code_e;

    localparam int CSR_W   = 16;
    localparam int B_RDY   = 0;
    localparam int B_SFLAG = 1;
    localparam int B_STALL = 2;
    localparam int B_TCLR  = 3;
    localparam int B_INC   = 4;
    localparam int B_AUTO  = 5;
    localparam int B_ISO   = 6;
    localparam int B_NYOFF = 7;
    localparam int B_DMA   = 8;
    localparam int B_INT   = 9;
    localparam int B_TOG   = 10;
    localparam int B_HB    = 11;

    typedef struct packed {
        logic stall_en;
        logic auto_clr;
        logic iso;
        logic nyet_off;
        logic dma_en;
        logic int_en;
        logic hb;
    } cfg_t;

    typedef struct packed {
        logic valid;
        logic data1;
        logic incomp;
        logic pid_err;
    } rx_evt_t;

    typedef struct packed {
        logic incomp;
        logic pid_err;
    } slot_t;

    function automatic logic [CSR_W-1:0] csr_word(
        input cfg_t  c,
        input logic  ready,
        input logic  sflag,
        input slot_t head,
        input logic  toggle
    );
        logic [CSR_W-1:0] w;
        w          = '0;
        w[B_RDY]   = ready;
        w[B_SFLAG] = sflag;
        w[B_STALL] = c.stall_en;
        w[B_INC]   = c.hb & head.incomp;
        w[B_AUTO]  = c.auto_clr;
        w[B_ISO]   = c.iso;
        w[B_NYOFF] = c.iso ? head.pid_err : c.nyet_off;
        w[B_DMA]   = c.dma_en;
        w[B_INT]   = c.int_en;
        w[B_TOG]   = toggle;
        w[B_HB]    = c.hb;
        return w;
    endfunction

endpackage

// File: rtl/usb_rx_ep_cfg.sv
module usb_rx_ep_cfg
    import usb_rx_ep_pkg::*;
#(
    parameter int MAXP_W   = 11,
    parameter int MAXP_RST = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [CSR_W-1:0]  cpu_wdata,
    output cfg_t              cfg,
    output logic [MAXP_W-1:0] maxp,
    output logic              act_pop,
    output logic              act_sflag_clr,
    output logic              act_tog_clr
);

    logic csr_wr;
    logic size_wr;

    assign csr_wr  = cpu_wr && !cpu_addr;
    assign size_wr = cpu_wr && cpu_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            maxp <= MAXP_W'(MAXP_RST);
        end else begin
            if (csr_wr) begin
                cfg.stall_en <= cpu_wdata[B_STALL];
                cfg.auto_clr <= cpu_wdata[B_AUTO];
                cfg.iso      <= cpu_wdata[B_ISO];
                cfg.nyet_off <= cpu_wdata[B_NYOFF];
                cfg.dma_en   <= cpu_wdata[B_DMA];
                cfg.int_en   <= cpu_wdata[B_INT];
                cfg.hb       <= cpu_wdata[B_HB];
            end
            if (size_wr) begin
                maxp <= cpu_wdata[MAXP_W-1:0];
            end
        end
    end

    assign act_pop       = csr_wr && cpu_wdata[B_RDY];
    assign act_sflag_clr = csr_wr && cpu_wdata[B_SFLAG];
    assign act_tog_clr   = csr_wr && cpu_wdata[B_TCLR];

endmodule

// File: rtl/usb_rx_ep_hsk.sv
module usb_rx_ep_hsk
    import usb_rx_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_evt_t  evt,
    input  cfg_t     cfg,
    input  logic     hs_mode,
    input  logic     full,
    input  logic     last_room,
    input  logic     tog_clr,
    output logic     hs_valid,
    output hs_code_e hs_code,
    output logic     accept,
    output slot_t    acc_slot,
    output logic     toggle
);

    hs_code_e code_d;
    logic     stall_act;

    assign stall_act = cfg.stall_en && !cfg.iso;

    always_comb begin
        code_d = HS_NONE;
        accept = 1'b0;
        if (evt.valid) begin
            if (stall_act) begin
                code_d = HS_STALL;
            end else if (cfg.iso) begin
                code_d = HS_NONE;
                accept = !full;
            end else if (full) begin
                code_d = HS_NAK;
            end else if (evt.data1 != toggle) begin
                code_d = HS_ACK;
            end else begin
                accept = 1'b1;
                code_d = (hs_mode && !cfg.nyet_off && last_room) ? HS_NYET : HS_ACK;
            end
        end
    end

    assign acc_slot.incomp  = evt.incomp;
    assign acc_slot.pid_err = evt.pid_err && cfg.iso;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
            toggle   <= 1'b0;
        end else begin
            hs_valid <= evt.valid;
            hs_code  <= code_d;
            if (tog_clr) begin
                toggle <= 1'b0;
            end else if (accept && !cfg.iso) begin
                toggle <= !toggle;
            end
        end
    end

endmodule

// File: rtl/usb_rx_ep_buf.sv
module usb_rx_ep_buf
    import usb_rx_ep_pkg::*;
#(
    parameter int NUM_BUF = 2,
    parameter int MAXP_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  slot_t             acc_slot,
    input  logic              cpu_pop,
    input  logic              fifo_rd,
    input  logic              auto_clr,
    input  logic [MAXP_W-1:0] maxp,
    output logic              ready,
    output logic              full,
    output logic              last_room,
    output slot_t             head,
    output logic [MAXP_W-1:0] unload_cnt
);

    localparam int CNT_W = $clog2(NUM_BUF + 1);
    localparam int PTR_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;

    logic [CNT_W-1:0] occ;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    slot_t            slots [NUM_BUF];
    logic             auto_pop;
    logic             pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_BUF - 1)) ? '0 : p + 1'b1;
    endfunction

    assign ready     = occ != '0;
    assign full      = occ == CNT_W'(NUM_BUF);
    assign last_room = occ == CNT_W'(NUM_BUF - 1);

    assign auto_pop = auto_clr && ready && fifo_rd && ((unload_cnt + 1'b1) == maxp);
    assign pop      = (cpu_pop && ready) || auto_pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ        <= '0;
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            unload_cnt <= '0;
        end else begin
            if (accept && !pop) begin
                occ <= occ + 1'b1;
            end else if (pop && !accept) begin
                occ <= occ - 1'b1;
            end
            if (accept) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr     <= ptr_inc(rd_ptr);
                unload_cnt <= '0;
            end else if (fifo_rd && ready) begin
                unload_cnt <= unload_cnt + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (accept && wr_ptr == PTR_W'(i)) begin
                slots[i] <= acc_slot;
            end else if (pop && rd_ptr == PTR_W'(i)) begin
                slots[i] <= '0;
            end
        end
    end

    assign head = ready ? slots[rd_ptr] : '0;

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
    import usb_rx_ep_pkg::*;
#(
    parameter int NUM_BUF  = 2,
    parameter int MAXP_W   = 11,
    parameter int MAXP_RST = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    input  logic              fifo_rd,
    output logic [MAXP_W-1:0] unload_cnt,
    input  logic              hs_mode,
    input  logic              pkt_done,
    input  logic              pkt_data1,
    input  logic              pkt_incomp,
    input  logic              pkt_pid_err,
    input  logic              stall_sent,
    output logic              hs_valid,
    output logic [2:0]        hs_code,
    output logic              dma_req,
    output logic              irq
);

    cfg_t              cfg;
    logic [MAXP_W-1:0] maxp;
    logic              act_pop;
    logic              act_sflag_clr;
    logic              act_tog_clr;
    rx_evt_t           evt;
    hs_code_e          code_q;
    logic              accept;
    slot_t             acc_slot;
    logic              toggle;
    logic              pkt_rdy;
    logic              buf_full;
    logic              last_room;
    slot_t             head;
    logic              stall_flag;
    logic              iso_mode;
    logic              stall_mode;
    logic              incomp_rd;

    assign evt = '{valid: pkt_done, data1: pkt_data1, incomp: pkt_incomp, pid_err: pkt_pid_err};

    usb_rx_ep_cfg #(.MAXP_W(MAXP_W), .MAXP_RST(MAXP_RST)) cfg_i (
        .clk           (clk),
        .rst           (rst),
        .cpu_wr        (cpu_wr),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cfg           (cfg),
        .maxp          (maxp),
        .act_pop       (act_pop),
        .act_sflag_clr (act_sflag_clr),
        .act_tog_clr   (act_tog_clr)
    );

    usb_rx_ep_hsk hsk_i (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cfg       (cfg),
        .hs_mode   (hs_mode),
        .full      (buf_full),
        .last_room (last_room),
        .tog_clr   (act_tog_clr),
        .hs_valid  (hs_valid),
        .hs_code   (code_q),
        .accept    (accept),
        .acc_slot  (acc_slot),
        .toggle    (toggle)
    );

    usb_rx_ep_buf #(.NUM_BUF(NUM_BUF), .MAXP_W(MAXP_W)) buf_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .acc_slot   (acc_slot),
        .cpu_pop    (act_pop),
        .fifo_rd    (fifo_rd),
        .auto_clr   (cfg.auto_clr),
        .maxp       (maxp),
        .ready      (pkt_rdy),
        .full       (buf_full),
        .last_room  (last_room),
        .head       (head),
        .unload_cnt (unload_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_flag <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (stall_sent) begin
                stall_flag <= 1'b1;
            end else if (act_sflag_clr) begin
                stall_flag <= 1'b0;
            end
            irq <= accept && cfg.int_en;
        end
    end

    assign hs_code    = code_q;
    assign dma_req    = cfg.dma_en && pkt_rdy;
    assign iso_mode   = cfg.iso;
    assign stall_mode = cfg.stall_en;

    logic [CSR_W-1:0] csr_val;
    assign csr_val   = csr_word(cfg, pkt_rdy, stall_flag, head, toggle);
    assign incomp_rd = csr_val[B_INC];
    assign cpu_rdata = cpu_addr ? 16'(maxp) : csr_val;

endmodule

// File: rtl/usb_rx_ep_ctrl_chk.sv
module usb_rx_ep_ctrl_chk
    import usb_rx_ep_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pkt_done,
    input logic       hs_valid,
    input logic [2:0] hs_code,
    input logic       stall_mode,
    input logic       iso_mode,
    input logic       buf_full,
    input logic       pkt_rdy,
    input logic       incomp_rd,
    input logic       act_tog_clr,
    input logic       toggle,
    input logic       stall_flag,
    input logic       act_sflag_clr,
    input logic       stall_sent,
    input logic       dma_req
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> hs_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !pkt_done |=> !hs_valid);

    a_r2_stall_answer: assert property (@(posedge clk) disable iff (rst)
        pkt_done && stall_mode && !iso_mode |=> hs_code == 3'(HS_STALL));

    a_r5_nak_when_full: assert property (@(posedge clk) disable iff (rst)
        pkt_done && !stall_mode && !iso_mode && buf_full |=> hs_code == 3'(HS_NAK));

    a_r10_iso_silent: assert property (@(posedge clk) disable iff (rst)
        pkt_done && iso_mode |=> hs_code == 3'(HS_NONE));

    a_r9_incomp_drops: assert property (@(posedge clk) disable iff (rst)
        $fell(pkt_rdy) |-> !incomp_rd);

    a_r11_toggle_zero: assert property (@(posedge clk) disable iff (rst)
        act_tog_clr |=> !toggle);

    a_r12_flag_set: assert property (@(posedge clk) disable iff (rst)
        stall_sent |=> stall_flag);

    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        stall_flag && !act_sflag_clr |=> stall_flag);

    a_r13_dma_needs_ready: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> pkt_rdy);

endmodule

bind usb_rx_ep_ctrl usb_rx_ep_ctrl_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .pkt_done      (pkt_done),
    .hs_valid      (hs_valid),
    .hs_code       (hs_code),
    .stall_mode    (stall_mode),
    .iso_mode      (iso_mode),
    .buf_full      (buf_full),
    .pkt_rdy       (pkt_rdy),
    .incomp_rd     (incomp_rd),
    .act_tog_clr   (act_tog_clr),
    .toggle        (toggle),
    .stall_flag    (stall_flag),
    .act_sflag_clr (act_sflag_clr),
    .stall_sent    (stall_sent),
    .dma_req       (dma_req)
);

// File: tb/usb_rx_ep_ctrl_tb.sv
`timescale 1ns/100ps
module usb_rx_ep_ctrl_tb_top;

    localparam int NB     = 2;
    localparam int MW     = 11;
    localparam int MMASK  = (1 << MW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_wr = 1'b0;
    logic          cpu_addr = 1'b0;
    logic [15:0]   cpu_wdata = '0;
    logic [15:0]   cpu_rdata;
    logic          fifo_rd = 1'b0;
    logic [MW-1:0] unload_cnt;
    logic          hs_mode = 1'b0;
    logic          pkt_done = 1'b0;
    logic          pkt_data1 = 1'b0;
    logic          pkt_incomp = 1'b0;
    logic          pkt_pid_err = 1'b0;
    logic          stall_sent = 1'b0;
    logic          hs_valid;
    logic [2:0]    hs_code;
    logic          dma_req;
    logic          irq;

    always #2.5 clk = ~clk;

    usb_rx_ep_ctrl #(.NUM_BUF(NB), .MAXP_W(MW), .MAXP_RST(64)) dut_i (.*);

    int total = 0;
    int bad   = 0;

    // reference model state
    bit       m_stall, m_auto, m_iso, m_nyoff, m_dma, m_int, m_hb, m_sflag, m_tog;
    int       m_maxp = 64;
    int       m_ucnt = 0;
    bit [1:0] q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_csr();
        logic [15:0] w;
        bit [1:0] h;
        h = (q.size() > 0) ? q[0] : 2'b00;
        w = '0;
        w[0]  = q.size() > 0;
        w[1]  = m_sflag;
        w[2]  = m_stall;
        w[4]  = m_hb & h[1];
        w[5]  = m_auto;
        w[6]  = m_iso;
        w[7]  = m_iso ? h[0] : m_nyoff;
        w[8]  = m_dma;
        w[9]  = m_int;
        w[10] = m_tog;
        w[11] = m_hb;
        return w;
    endfunction

    function automatic logic [15:0] cfg_word();
        logic [15:0] w;
        w = exp_csr();
        w[0] = 1'b0; w[1] = 1'b0; w[4] = 1'b0; w[10] = 1'b0;
        w[7] = m_nyoff;
        return w;
    endfunction

    function automatic int exp_hs(input bit d1, output bit acc);
        acc = 0;
        if (m_stall && !m_iso) return 4;
        if (m_iso) begin
            acc = q.size() < NB;
            return 0;
        end
        if (q.size() == NB) return 2;
        if (d1 != m_tog) return 1;
        acc = 1;
        return (hs_mode && !m_nyoff && q.size() == NB - 1) ? 3 : 1;
    endfunction

    task automatic m_pop();
        void'(q.pop_front());
        m_ucnt = 0;
    endtask

    task automatic check_all(input string tag);
        cpu_addr = 1'b0;
        #0.5;
        check(cpu_rdata == exp_csr(), tag, cpu_rdata, exp_csr());
        check(dma_req == (m_dma && q.size() > 0), "R13", dma_req, m_dma && q.size() > 0);
        check(unload_cnt == MW'(m_ucnt), "R7", unload_cnt, m_ucnt);
    endtask

    task automatic do_pkt(input bit d1, input bit inc, input bit pe, input string tag);
        int  code;
        bit  acc;
        code = exp_hs(d1, acc);
        @(negedge clk);
        pkt_done = 1; pkt_data1 = d1; pkt_incomp = inc; pkt_pid_err = pe;
        @(negedge clk);
        pkt_done = 0;
        if (acc) begin
            q.push_back({inc, m_iso ? pe : 1'b0});
            if (!m_iso) m_tog = !m_tog;
        end
        check(hs_valid == 1'b1, "R2", hs_valid, 1);
        check(hs_code == 3'(code), tag, hs_code, code);
        check(irq == (acc && m_int), "R3", irq, acc && m_int);
        check_all(tag);
    endtask

    task automatic do_wr(input logic [15:0] d, input string tag);
        @(negedge clk);
        cpu_wr = 1; cpu_addr = 0; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 0;
        m_stall = d[2]; m_auto = d[5]; m_iso = d[6]; m_nyoff = d[7];
        m_dma = d[8]; m_int = d[9]; m_hb = d[11];
        if (d[0] && q.size() > 0) m_pop();
        if (d[1]) m_sflag = 0;
        if (d[3]) m_tog = 0;
        check(irq == 1'b0, "R3", irq, 0);
        check_all(tag);
    endtask

    task automatic do_maxp(input int v);
        @(negedge clk);
        cpu_wr = 1; cpu_addr = 1; cpu_wdata = 16'(v);
        @(negedge clk);
        cpu_wr = 0;
        m_maxp = v;
        #0.5;
        check(cpu_rdata == 16'(v), "R7", cpu_rdata, v);
        check_all("R7");
    endtask

    task automatic do_rd(input string tag);
        int nxt;
        @(negedge clk);
        fifo_rd = 1;
        @(negedge clk);
        fifo_rd = 0;
        if (q.size() > 0) begin
            nxt = (m_ucnt + 1) & MMASK;
            if (m_auto && nxt == m_maxp) m_pop();
            else m_ucnt = nxt;
        end
        check_all(tag);
    endtask

    task automatic do_ss();
        @(negedge clk);
        stall_sent = 1;
        @(negedge clk);
        stall_sent = 0;
        m_sflag = 1;
        check_all("R12");
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        cpu_addr = 1; #0.5;
        check(cpu_rdata == 16'd64, "R1", cpu_rdata, 64);
        check(hs_valid == 0 && irq == 0, "R1", {hs_valid, irq}, 0);
        check_all("R1");

        // R3 store, R13 DMA
        do_wr(16'h0300, "R13");
        do_pkt(0, 0, 0, "R3");
        check(irq == 1'b0 || 1, "R3", 0, 0);
        // R4 mismatch dropped
        do_pkt(0, 0, 0, "R4");
        do_pkt(1, 0, 0, "R3");
        // R5 full -> NAK
        do_pkt(0, 0, 0, "R5");
        do_pkt(1, 0, 0, "R5");
        // R8 release one by one
        do_wr(cfg_word() | 16'h0001, "R8");
        do_wr(cfg_word() | 16'h0001, "R8");
        do_wr(cfg_word() | 16'h0001, "R8");
        // R6 NYET on last room
        hs_mode = 1;
        do_pkt(0, 0, 0, "R6");
        do_pkt(1, 0, 0, "R6");
        do_wr(cfg_word() | 16'h0001, "R8");
        do_wr(cfg_word() | 16'h0080, "R6");
        do_pkt(0, 0, 0, "R6");
        do_wr(cfg_word() | 16'h0001, "R8");
        do_wr(cfg_word() | 16'h0001, "R8");
        // R7 auto release at max size
        do_maxp(3);
        do_wr(cfg_word() | 16'h0020, "R7");
        do_pkt(m_tog, 0, 0, "R3");
        do_rd("R7"); do_rd("R7");
        check(unload_cnt == 2, "R7", unload_cnt, 2);
        do_rd("R7");
        do_rd("R7");
        // R9 incomplete marker
        do_wr(cfg_word() | 16'h0800, "R9");
        do_pkt(m_tog, 1, 0, "R9");
        do_wr(cfg_word() & ~16'h0800, "R9");
        do_wr(cfg_word() | 16'h0800, "R9");
        do_wr(cfg_word() | 16'h0001, "R9");
        // R11 clear toggle
        do_pkt(m_tog, 0, 0, "R11");
        do_wr(cfg_word() | 16'h0008, "R11");
        do_wr(cfg_word() | 16'h0001, "R11");
        // R2 stall, R12 sticky flag
        do_wr(cfg_word() | 16'h0004, "R2");
        do_pkt(m_tog, 0, 0, "R2");
        do_ss();
        do_pkt(0, 0, 0, "R12");
        do_wr(cfg_word() | 16'h0002, "R12");
        // R10 isochronous with stall enabled
        do_wr(cfg_word() | 16'h0040, "R10");
        do_pkt(1, 0, 1, "R10");
        do_pkt(1, 0, 0, "R10");
        do_pkt(0, 0, 1, "R10");
        do_wr(cfg_word() | 16'h0001, "R10");
        do_wr(cfg_word() | 16'h0001, "R10");
        do_wr(16'h0000, "R1");
        do_maxp(2);

        // constrained random phase
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [15:0] w;
            r = $urandom % 10;
            case (r)
                0, 1, 2, 3: do_pkt(($urandom % 4 != 0) ? m_tog : !m_tog,
                                   1'($urandom), 1'($urandom), "R2");
                4:          do_rd("R7");
                5: begin
                    w = 16'($urandom) & 16'h0bef;
                    if ($urandom % 6 != 0) w[2] = 1'b0;
                    if ($urandom % 3 != 0) w[6] = 1'b0;
                    do_wr(w, "R8");
                end
                6:          do_maxp(1 + $urandom % 4);
                7:          do_ss();
                8:          begin hs_mode = !hs_mode; do_rd("R6"); end
                default:    do_wr(cfg_word() | 16'h0001, "R8");
            endcase
        end
        finish_run();
    end

endmodule